// File: doc/BRIEF.md
# Interrupt Gate Validation Sequencer

This block decides what happens when an interrupt or exception reaches a protected-mode processor core. It takes an interrupt vector, the descriptor table limit, the fields of the gate descriptor found at that vector, and the fields of the code-segment descriptor that the gate names. It then runs the protection checks in a fixed priority order. The result is one of two things: a fault class with the error code that the exception frame would carry, or a dispatch decision. The dispatch decision is task switch, entry at an inner privilege level, or entry at the same privilege level.

Descriptor fetches happen outside the block and reach it as fields that are already decoded. A single `start` pulse captures every input. After that the sequencer makes one check per clock, and the first check that fails ends the run. The result stays on the outputs until the next accepted start, so the stack-push and task-switch logic that follows can consume it at its own pace. The error code takes one of three forms. A fault on the gate uses a vector-based code, a fault on the target segment uses a selector-based code, and a null selector gives a code that carries only the external-event bit.

Top module: `gate_check_top`

## Requirements
- R1: After reset, `busy`, `done`, `faultClass`, `dispatch` and `errCode` are all zero.
- R2: When `start` is high and `busy` is low, all inputs are captured on that clock edge and `busy` rises. The checks then run one per clock in this order: 1 vector limit, 2 gate kind, 3 gate privilege, 4 gate present, 5 null selector, 6 selector limit, 7 segment kind, 8 segment present, 9 privilege decision. The result and `done` appear N clock edges after the capturing edge, where N is the number of the deciding check. `start` is ignored while `busy` is high.
- R3: If vector*8+7 is greater than `tableLimit`, the result is a general-protection fault (faultClass 1) with errCode = vector*8+2+extEvent.
- R4: If `gateKind` is not 1 (interrupt gate), 2 (trap gate) or 3 (task gate), the result is faultClass 1 with the vector-based code of R3.
- R5: If `swOrigin` is 1 and `gateDpl` is numerically less than `cpl`, the result is faultClass 1 with the vector-based code. When `swOrigin` is 0, this check always passes.
- R6: If `gatePresent` is 0, the result is a not-present fault (faultClass 2) with the vector-based code.
- R7: A present task gate (gateKind 3) ends the run at check 4 with dispatch 1 (task switch) and faultClass 0.
- R8: If codeSel[15:2] is zero (null selector, whatever the two low bits hold), the result is faultClass 1 with errCode = extEvent.
- R9: If codeSel with bits [2:0] forced to 7 is greater than `codeTableLimit`, or `codeIsCode` is 0, the result is faultClass 1 with the selector code: codeSel with bit 1 cleared and bit 0 replaced by extEvent. The limit test has the higher priority.
- R10: If `codePresent` is 0, the result is faultClass 2 with the selector code.
- R11: A non-conforming segment with codeDpl < cpl gives dispatch 2 (inner privilege). Otherwise, a conforming segment or codeDpl = cpl gives dispatch 3 (same privilege). Any other case is faultClass 1 with the selector code.
- R12: While `done` is high, exactly one of faultClass and dispatch is nonzero. All outputs hold their values, whatever the data inputs do, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a validation run (accepted when idle) |
| vector | input | 8 | Interrupt vector number |
| tableLimit | input | 16 | Interrupt descriptor table byte limit |
| gateKind | input | 3 | Gate type: 1 interrupt, 2 trap, 3 task, other invalid |
| gateDpl | input | 2 | Gate descriptor privilege level |
| gatePresent | input | 1 | Gate present bit |
| cpl | input | 2 | Current privilege level |
| swOrigin | input | 1 | Request came from a software interrupt instruction |
| extEvent | input | 1 | Request came from an external event |
| codeSel | input | 16 | Code-segment selector taken from the gate |
| codeTableLimit | input | 16 | Byte limit of the table the selector indexes |
| codeIsCode | input | 1 | Target descriptor is a code segment |
| codeConforming | input | 1 | Target code segment is conforming |
| codeDpl | input | 2 | Target code segment privilege level |
| codePresent | input | 1 | Target segment present bit |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid, held until next start |
| faultClass | output | 2 | 0 none, 1 general protection, 2 not present |
| errCode | output | 16 | Error code for the fault |
| dispatch | output | 2 | 0 none, 1 task switch, 2 inner privilege, 3 same privilege |

## Verification
A sequencer that skips a state, or advances in the wrong order, shows up as a wrong latency. It can also let a lower-priority fault win when several checks fail at once. The bench arranges such overlaps and measures the edge count of each run. A wrong error-code source shows up only in the low bits of `errCode`: bit 1 and the placement of the external-event bit. So each fault is tried with both values of `extEvent`. Any corruption of the held result is visible on the cycle after it happens. The bench watches for it by changing inputs and pulsing `start` while results are held or a run is busy.

// File: rtl/gate_check_pkg.sv
package gate_check_pkg;

  localparam logic [2:0] KIND_INTR = 3'd1;
  localparam logic [2:0] KIND_TRAP = 3'd2;
  localparam logic [2:0] KIND_TASK = 3'd3;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_VLIM  = 4'd1,
    ST_GKIND = 4'd2,
    ST_GDPL  = 4'd3,
    ST_GPRES = 4'd4,
    ST_CNULL = 4'd5,
    ST_CLIM  = 4'd6,
    ST_CKIND = 4'd7,
    ST_CPRES = 4'd8,
    ST_CPRIV = 4'd9
  } stateT;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2
  } faultT;

  typedef enum logic [1:0] {
    DSP_NONE  = 2'd0,
    DSP_TASK  = 2'd1,
    DSP_INNER = 2'd2,
    DSP_SAME  = 2'd3
  } dispT;

  typedef enum logic [1:0] {
    ERR_ZERO = 2'd0,
    ERR_VEC  = 2'd1,
    ERR_SEL  = 2'd2,
    ERR_EXT  = 2'd3
  } errSrcT;

  // control -> datapath
  typedef struct packed {
    logic   capture;
    logic   finish;
    faultT  fault;
    errSrcT errSrc;
    dispT   disp;
  } strobeT;

  // datapath -> control
  typedef struct packed {
    logic vecLimFail;
    logic kindBad;
    logic isTask;
    logic dplFail;
    logic gateAbsent;
    logic selNull;
    logic selLimFail;
    logic notCode;
    logic codeAbsent;
    logic goInner;
    logic goSame;
  } statusT;

endpackage

// File: rtl/gate_check_dp.sv
module gate_check_dp
  import gate_check_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int SEL_W = 16,
  parameter int LIM_W = 16,
  parameter int DPL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobeT           strb,
  input  logic [VEC_W-1:0] vector,
  input  logic [LIM_W-1:0] tableLimit,
  input  logic [2:0]       gateKind,
  input  logic [DPL_W-1:0] gateDpl,
  input  logic             gatePresent,
  input  logic [DPL_W-1:0] cpl,
  input  logic             swOrigin,
  input  logic             extEvent,
  input  logic [SEL_W-1:0] codeSel,
  input  logic [LIM_W-1:0] codeTableLimit,
  input  logic             codeIsCode,
  input  logic             codeConforming,
  input  logic [DPL_W-1:0] codeDpl,
  input  logic             codePresent,
  output statusT           stat,
  output logic             done,
  output logic [1:0]       faultClass,
  output logic [SEL_W-1:0] errCode,
  output logic [1:0]       dispatch
);

  localparam int VTOP_W = VEC_W + 3;
  localparam int CMP_W  = ((VTOP_W > LIM_W) ? VTOP_W : LIM_W) + 1;
  localparam int SCMP_W = ((SEL_W > LIM_W) ? SEL_W : LIM_W) + 1;
  localparam int VPAD_W = SEL_W - VTOP_W;

  // captured request
  logic [VEC_W-1:0] vecQ;
  logic [LIM_W-1:0] tabLimQ;
  logic [2:0]       kindQ;
  logic [DPL_W-1:0] gDplQ;
  logic             gPresQ;
  logic [DPL_W-1:0] cplQ;
  logic             swQ;
  logic             extQ;
  logic [SEL_W-1:0] selQ;
  logic [LIM_W-1:0] cLimQ;
  logic             isCodeQ;
  logic             confQ;
  logic [DPL_W-1:0] cDplQ;
  logic             cPresQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vecQ    <= '0;
      tabLimQ <= '0;
      kindQ   <= '0;
      gDplQ   <= '0;
      gPresQ  <= 1'b0;
      cplQ    <= '0;
      swQ     <= 1'b0;
      extQ    <= 1'b0;
      selQ    <= '0;
      cLimQ   <= '0;
      isCodeQ <= 1'b0;
      confQ   <= 1'b0;
      cDplQ   <= '0;
      cPresQ  <= 1'b0;
    end else if (strb.capture) begin
      vecQ    <= vector;
      tabLimQ <= tableLimit;
      kindQ   <= gateKind;
      gDplQ   <= gateDpl;
      gPresQ  <= gatePresent;
      cplQ    <= cpl;
      swQ     <= swOrigin;
      extQ    <= extEvent;
      selQ    <= codeSel;
      cLimQ   <= codeTableLimit;
      isCodeQ <= codeIsCode;
      confQ   <= codeConforming;
      cDplQ   <= codeDpl;
      cPresQ  <= codePresent;
    end
  end

  // check conditions on the captured request
  logic [CMP_W-1:0]  vecTop;
  logic [CMP_W-1:0]  tabLimExt;
  logic [SCMP_W-1:0] selTop;
  logic [SCMP_W-1:0] cLimExt;

  always_comb begin
    vecTop    = CMP_W'({vecQ, 3'b111});
    tabLimExt = CMP_W'(tabLimQ);
    selTop    = SCMP_W'({selQ[SEL_W-1:3], 3'b111});
    cLimExt   = SCMP_W'(cLimQ);

    stat.vecLimFail = vecTop > tabLimExt;
    stat.kindBad    = !((kindQ == KIND_INTR) || (kindQ == KIND_TRAP) ||
                        (kindQ == KIND_TASK));
    stat.isTask     = kindQ == KIND_TASK;
    stat.dplFail    = swQ && (gDplQ < cplQ);
    stat.gateAbsent = !gPresQ;
    stat.selNull    = selQ[SEL_W-1:2] == '0;
    stat.selLimFail = selTop > cLimExt;
    stat.notCode    = !isCodeQ;
    stat.codeAbsent = !cPresQ;
    stat.goInner    = !confQ && (cDplQ < cplQ);
    stat.goSame     = confQ || (cDplQ == cplQ);
  end

  // error code forms
  logic [SEL_W-1:0] vecCode;
  logic [SEL_W-1:0] selCode;
  logic [SEL_W-1:0] extCode;
  logic [SEL_W-1:0] pickCode;

  always_comb begin
    vecCode = {{VPAD_W{1'b0}}, vecQ, 2'b01, extQ};
    selCode = {selQ[SEL_W-1:2], 1'b0, extQ};
    extCode = {{(SEL_W-1){1'b0}}, extQ};
    unique case (strb.errSrc)
      ERR_VEC: pickCode = vecCode;
      ERR_SEL: pickCode = selCode;
      ERR_EXT: pickCode = extCode;
      default: pickCode = '0;
    endcase
  end

  // held result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      faultClass <= 2'd0;
      errCode    <= '0;
      dispatch   <= 2'd0;
    end else if (strb.capture) begin
      done       <= 1'b0;
      faultClass <= 2'd0;
      errCode    <= '0;
      dispatch   <= 2'd0;
    end else if (strb.finish) begin
      done       <= 1'b1;
      faultClass <= strb.fault;
      errCode    <= pickCode;
      dispatch   <= strb.disp;
    end
  end

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !strb.capture |=> done && $stable(faultClass) && $stable(errCode)
                              && $stable(dispatch));

  // R12
  fault_disp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((faultClass == 2'd0) != (dispatch == 2'd0)));

  // R7
  task_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (dispatch == DSP_TASK) |-> (kindQ == KIND_TASK) && gPresQ);

  // R11
  inner_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (dispatch == DSP_INNER) |-> !confQ && (cDplQ < cplQ));

  // R8
  null_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish && (strb.errSrc == ERR_EXT) |=> errCode[SEL_W-1:1] == '0);

endmodule

// File: rtl/gate_check_ctrl.sv
module gate_check_ctrl
  import gate_check_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  statusT stat,
  output strobeT strb,
  output logic   busy
);

  stateT state;
  stateT nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign busy = state != ST_IDLE;

  always_comb begin
    nextState   = state;
    strb.capture = 1'b0;
    strb.finish  = 1'b0;
    strb.fault   = FLT_NONE;
    strb.errSrc  = ERR_ZERO;
    strb.disp    = DSP_NONE;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.capture = 1'b1;
          nextState    = ST_VLIM;
        end
      end
      ST_VLIM: begin
        if (stat.vecLimFail) begin
          strb.finish = 1'b1; strb.fault = FLT_GP; strb.errSrc = ERR_VEC;
          nextState   = ST_IDLE;
        end else nextState = ST_GKIND;
      end
      ST_GKIND: begin
        if (stat.kindBad) begin
          strb.finish = 1'b1; strb.fault = FLT_GP; strb.errSrc = ERR_VEC;
          nextState   = ST_IDLE;
        end else nextState = ST_GDPL;
      end
      ST_GDPL: begin
        if (stat.dplFail) begin
          strb.finish = 1'b1; strb.fault = FLT_GP; strb.errSrc = ERR_VEC;
          nextState   = ST_IDLE;
        end else nextState = ST_GPRES;
      end
      ST_GPRES: begin
        if (stat.gateAbsent) begin
          strb.finish = 1'b1; strb.fault = FLT_NP; strb.errSrc = ERR_VEC;
          nextState   = ST_IDLE;
        end else if (stat.isTask) begin
          strb.finish = 1'b1; strb.disp = DSP_TASK;
          nextState   = ST_IDLE;
        end else nextState = ST_CNULL;
      end
      ST_CNULL: begin
        if (stat.selNull) begin
          strb.finish = 1'b1; strb.fault = FLT_GP; strb.errSrc = ERR_EXT;
          nextState   = ST_IDLE;
        end else nextState = ST_CLIM;
      end
      ST_CLIM: begin
        if (stat.selLimFail) begin
          strb.finish = 1'b1; strb.fault = FLT_GP; strb.errSrc = ERR_SEL;
          nextState   = ST_IDLE;
        end else nextState = ST_CKIND;
      end
      ST_CKIND: begin
        if (stat.notCode) begin
          strb.finish = 1'b1; strb.fault = FLT_GP; strb.errSrc = ERR_SEL;
          nextState   = ST_IDLE;
        end else nextState = ST_CPRES;
      end
      ST_CPRES: begin
        if (stat.codeAbsent) begin
          strb.finish = 1'b1; strb.fault = FLT_NP; strb.errSrc = ERR_SEL;
          nextState   = ST_IDLE;
        end else nextState = ST_CPRIV;
      end
      ST_CPRIV: begin
        strb.finish = 1'b1;
        nextState   = ST_IDLE;
        if (stat.goInner)     strb.disp = DSP_INNER;
        else if (stat.goSame) strb.disp = DSP_SAME;
        else begin
          strb.fault  = FLT_GP;
          strb.errSrc = ERR_SEL;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && (state == ST_VLIM));

  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (state != ST_VLIM) |-> $past(busy) &&
      (4'(state) == 4'($past(state)) + 4'd1));

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !strb.capture);

endmodule

// File: rtl/gate_check_top.sv
module gate_check_top
  import gate_check_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int SEL_W = 16,
  parameter int LIM_W = 16,
  parameter int DPL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] vector,
  input  logic [LIM_W-1:0] tableLimit,
  input  logic [2:0]       gateKind,
  input  logic [DPL_W-1:0] gateDpl,
  input  logic             gatePresent,
  input  logic [DPL_W-1:0] cpl,
  input  logic             swOrigin,
  input  logic             extEvent,
  input  logic [SEL_W-1:0] codeSel,
  input  logic [LIM_W-1:0] codeTableLimit,
  input  logic             codeIsCode,
  input  logic             codeConforming,
  input  logic [DPL_W-1:0] codeDpl,
  input  logic             codePresent,
  output logic             busy,
  output logic             done,
  output logic [1:0]       faultClass,
  output logic [SEL_W-1:0] errCode,
  output logic [1:0]       dispatch
);

  strobeT strb;
  statusT stat;

  gate_check_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .stat  (stat),
    .strb  (strb),
    .busy  (busy)
  );

  gate_check_dp #(
    .VEC_W (VEC_W),
    .SEL_W (SEL_W),
    .LIM_W (LIM_W),
    .DPL_W (DPL_W)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strb           (strb),
    .vector         (vector),
    .tableLimit     (tableLimit),
    .gateKind       (gateKind),
    .gateDpl        (gateDpl),
    .gatePresent    (gatePresent),
    .cpl            (cpl),
    .swOrigin       (swOrigin),
    .extEvent       (extEvent),
    .codeSel        (codeSel),
    .codeTableLimit (codeTableLimit),
    .codeIsCode     (codeIsCode),
    .codeConforming (codeConforming),
    .codeDpl        (codeDpl),
    .codePresent    (codePresent),
    .stat           (stat),
    .done           (done),
    .faultClass     (faultClass),
    .errCode        (errCode),
    .dispatch       (dispatch)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !busy && !done);

endmodule

// File: tb/gate_check_top_bench.sv
module gate_check_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vector = '0;
  logic [15:0] tableLimit = '0;
  logic [2:0]  gateKind = '0;
  logic [1:0]  gateDpl = '0;
  logic        gatePresent = 1'b0;
  logic [1:0]  cpl = '0;
  logic        swOrigin = 1'b0;
  logic        extEvent = 1'b0;
  logic [15:0] codeSel = '0;
  logic [15:0] codeTableLimit = '0;
  logic        codeIsCode = 1'b0;
  logic        codeConforming = 1'b0;
  logic [1:0]  codeDpl = '0;
  logic        codePresent = 1'b0;
  logic        busy, done;
  logic [1:0]  faultClass, dispatch;
  logic [15:0] errCode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gate_check_top u_gate_check_top (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector),
    .tableLimit(tableLimit), .gateKind(gateKind), .gateDpl(gateDpl),
    .gatePresent(gatePresent), .cpl(cpl), .swOrigin(swOrigin),
    .extEvent(extEvent), .codeSel(codeSel), .codeTableLimit(codeTableLimit),
    .codeIsCode(codeIsCode), .codeConforming(codeConforming),
    .codeDpl(codeDpl), .codePresent(codePresent), .busy(busy), .done(done),
    .faultClass(faultClass), .errCode(errCode), .dispatch(dispatch)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected result from the requirement text
  task automatic model(output int f, output int e, output int d,
                       output int n);
    int vcode, scode;
    vcode = vector * 8 + 2 + extEvent;
    scode = (codeSel & 16'hFFFC) + extEvent;
    f = 0; e = 0; d = 0;
    if (vector * 8 + 7 > tableLimit)            begin f = 1; e = vcode; n = 1; end
    else if (!(gateKind inside {3'd1, 3'd2, 3'd3})) begin f = 1; e = vcode; n = 2; end
    else if (swOrigin && gateDpl < cpl)         begin f = 1; e = vcode; n = 3; end
    else if (!gatePresent)                      begin f = 2; e = vcode; n = 4; end
    else if (gateKind == 3'd3)                  begin d = 1; n = 4; end
    else if ((codeSel >> 2) == 0)               begin f = 1; e = extEvent; n = 5; end
    else if ((codeSel | 16'h0007) > codeTableLimit) begin f = 1; e = scode; n = 6; end
    else if (!codeIsCode)                       begin f = 1; e = scode; n = 7; end
    else if (!codePresent)                      begin f = 2; e = scode; n = 8; end
    else begin
      n = 9;
      if (!codeConforming && codeDpl < cpl)          d = 2;
      else if (codeConforming || codeDpl == cpl)     d = 3;
      else begin f = 1; e = scode; end
    end
  endtask

  task automatic setGood();
    vector = 8'd32; tableLimit = 16'h07FF; gateKind = 3'd1; gateDpl = 2'd3;
    gatePresent = 1'b1; cpl = 2'd3; swOrigin = 1'b1; extEvent = 1'b0;
    codeSel = 16'h0008; codeTableLimit = 16'h00FF; codeIsCode = 1'b1;
    codeConforming = 1'b0; codeDpl = 2'd0; codePresent = 1'b1;
  endtask

  // pulse start, wait for done, compare against the model
  task automatic runCase(input string req);
    int f, e, d, n, edges;
    model(f, e, d, n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (!done && edges < 40) begin
      @(negedge clk);
      edges++;
    end
    check(req, "latency", edges, n);
    check(req, "faultClass", faultClass, f);
    check(req, "errCode", errCode, e);
    check(req, "dispatch", dispatch, d);
  endtask

  task automatic testReset();
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "faultClass", faultClass, 0);
    check("R1", "dispatch", dispatch, 0);
    check("R1", "errCode", errCode, 0);
  endtask

  task automatic testVecLimit();
    setGood(); vector = 8'd10; tableLimit = 16'h0057; codeDpl = 2'd3;
    runCase("R3");               // exactly at the limit: passes
    tableLimit = 16'h0056; runCase("R3");
    extEvent = 1'b1; runCase("R3");
    gateKind = 3'd0; runCase("R3"); // limit wins over kind
  endtask

  task automatic testKind();
    setGood(); gateKind = 3'd0; runCase("R4");
    gateKind = 3'd5; extEvent = 1'b1; runCase("R4");
    gateKind = 3'd2; codeDpl = 2'd3; runCase("R4");
  endtask

  task automatic testGateDpl();
    setGood(); gateDpl = 2'd0; runCase("R5");
    swOrigin = 1'b0; runCase("R5");  // hardware origin skips the test
    swOrigin = 1'b1; gateDpl = 2'd3; runCase("R5");
  endtask

  task automatic testGatePresent();
    setGood(); gatePresent = 1'b0; runCase("R6");
    extEvent = 1'b1; gateKind = 3'd3; runCase("R6");
  endtask

  task automatic testTask();
    setGood(); gateKind = 3'd3; codeSel = 16'h0000; runCase("R7");
  endtask

  task automatic testNull();
    setGood(); codeSel = 16'h0000; runCase("R8");
    codeSel = 16'h0003; extEvent = 1'b1; runCase("R8");
  endtask

  task automatic testSegLimit();
    setGood(); codeSel = 16'h0010; codeTableLimit = 16'h0017; runCase("R9");
    codeTableLimit = 16'h0016; codeIsCode = 1'b0; runCase("R9");
    codeTableLimit = 16'h0017; runCase("R9");
    codeSel = 16'h0013; extEvent = 1'b1; runCase("R9");
  endtask

  task automatic testSegPresent();
    setGood(); codePresent = 1'b0; runCase("R10");
    codeSel = 16'h001E; extEvent = 1'b1; runCase("R10");
  endtask

  task automatic testPriv();
    setGood(); runCase("R11");                            // inner
    codeConforming = 1'b1; runCase("R11");                // same
    codeConforming = 1'b0; codeDpl = 2'd3; runCase("R11"); // same, equal
    cpl = 2'd1; gateDpl = 2'd1; codeDpl = 2'd2; runCase("R11"); // fault
    swOrigin = 1'b0; gateDpl = 2'd0; codeConforming = 1'b1; runCase("R11");
  endtask

  task automatic testHoldAndBusy();
    int eF, eE, eD, eN;
    setGood(); codeSel = 16'h0010; codeIsCode = 1'b0;
    model(eF, eE, eD, eN);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    setGood(); start = 1'b1;       // ignored while busy
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check("R2", "ignored start faultClass", faultClass, eF);
    check("R2", "ignored start errCode", errCode, eE);
    vector = 8'hFF; tableLimit = 16'h0; extEvent = 1'b1;
    repeat (5) @(negedge clk);
    check("R12", "held done", done, 1);
    check("R12", "held errCode", errCode, eE);
    check("R12", "held dispatch", dispatch, eD);
    check("R12", "idle busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testVecLimit();
    testKind();
    testGateDpl();
    testGatePresent();
    testTask();
    testNull();
    testSegLimit();
    testSegPresent();
    testPriv();
    testHoldAndBusy();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule